// File: doc/BRIEF.md
# Dual-Issue Pairing and Issue Check

This block is the issue decision of a statically scheduled, two-wide, in-order pipeline. Each cycle the decode stage presents a window of two decoded instructions, slot 0 older than slot 1. Each slot carries a valid flag, a 3-bit class code, two optional source registers and an optional destination register. The block decides whether none, one or both instructions leave the window this cycle. It steers each issued instruction to the integer pipe or the floating-point pipe. It also reports the number of slots consumed, so the fetch buffer can shift any leftover instruction into slot 0 for the next cycle.

An issued pair must behave exactly as if the two instructions had issued one after the other. Both issue together only when one is integer-class and the other is floating-point, neither is a branch, and the younger one neither reads nor rewrites the older one's destination. Register availability comes from two places. The first is an external busy vector from the execution stages. The second is a small internal tracker that keeps the destination of every issued floating-point operation busy while that operation runs its three execute cycles.

Top module: `dual_issue_ctl`

## Requirements
- R1: `issue_cnt` gives the number of instructions issued this cycle as 0, 1 or 2, and never takes the value 3.
- R2: Both slots issue together only if one class is integer-class (codes 0 ALU, 1 load, 2 store, 3 branch; bit 2 clear) and the other is floating-point (bit 2 set, e.g. 4 add, 5 multiply). Two integer-class or two floating-point instructions issue only the older one.
- R3: An instruction of class code 3 (branch) never shares its cycle: with a branch in either slot, at most one instruction issues.
- R4: If slot 0 writes a register (`s0_rd_en`) that slot 1 reads through an enabled source or also writes, only slot 0 issues. A slot 0 with no destination never blocks slot 1.
- R5: Issue is in program order. Slot 1 issues only in a cycle in which slot 0 issues, and an invalid slot 0 gives a count of 0.
- R6: A slot whose enabled source register or enabled destination register is busy does not issue, and neither does any younger slot. Register fields whose enable is low are ignored.
- R7: A floating-point instruction issued with its destination enabled marks that register busy for the `FP_LAT` (default 3) cycles after the issue edge. A dependent instruction stalls in those cycles and issues in the next one. This applies from either slot.
- R8: `int_vld`/`int_slot` and `fp_vld`/`fp_slot` name the slot sent to each pipe (slot field 0 = slot 0, 1 = slot 1). The number of pipes with a valid flag equals `issue_cnt`.
- R9: Reset clears every internal busy mark, so an instruction that depends on a floating-point result issued before reset can issue right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_vld | input | 1 | Slot 0 (older) holds an instruction |
| s0_cls | input | 3 | Slot 0 class code |
| s0_ra | input | RW | Slot 0 first source register |
| s0_ra_en | input | 1 | Slot 0 first source in use |
| s0_rb | input | RW | Slot 0 second source register |
| s0_rb_en | input | 1 | Slot 0 second source in use |
| s0_rd | input | RW | Slot 0 destination register |
| s0_rd_en | input | 1 | Slot 0 writes its destination |
| s1_vld | input | 1 | Slot 1 (younger) holds an instruction |
| s1_cls | input | 3 | Slot 1 class code |
| s1_ra | input | RW | Slot 1 first source register |
| s1_ra_en | input | 1 | Slot 1 first source in use |
| s1_rb | input | RW | Slot 1 second source register |
| s1_rb_en | input | 1 | Slot 1 second source in use |
| s1_rd | input | RW | Slot 1 destination register |
| s1_rd_en | input | 1 | Slot 1 writes its destination |
| ext_busy | input | NREG | Busy bits from the execution stages, one per register |
| issue_cnt | output | 2 | Instructions issued this cycle |
| int_vld | output | 1 | An instruction goes to the integer pipe |
| int_slot | output | 1 | Slot sent to the integer pipe |
| fp_vld | output | 1 | An instruction goes to the floating-point pipe |
| fp_slot | output | 1 | Slot sent to the floating-point pipe |

## Verification
The issue decision is combinational from the window and the busy state. A wrong pairing or ordering decision therefore shows on `issue_cnt` and the pipe selects in the same cycle the window is presented. The only stored state is the floating-point latency tracker. An error there shows up one to `FP_LAT` cycles later, as a dependent instruction that issues too early, stalls too long, or stays blocked after reset. The bench presents a dependent instruction in each cycle after a floating-point issue to catch that.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  typedef enum logic [2:0] {
    CL_ALU    = 3'd0,
    CL_LOAD   = 3'd1,
    CL_STORE  = 3'd2,
    CL_BRANCH = 3'd3,
    CL_FADD   = 3'd4,
    CL_FMUL   = 3'd5,
    CL_FMOV   = 3'd6,
    CL_FCVT   = 3'd7
  } iclass_e;

  // floating-point family: class bit 2 set
  function automatic logic cls_is_fp(logic [2:0] c);
    return c[2];
  endfunction

  function automatic logic cls_is_br(logic [2:0] c);
    return iclass_e'(c) == CL_BRANCH;
  endfunction

endpackage

// File: rtl/di_slot_hazard.sv
module di_slot_hazard #(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic            vld,
  input  logic [RW-1:0]   ra,
  input  logic            ra_en,
  input  logic [RW-1:0]   rb,
  input  logic            rb_en,
  input  logic [RW-1:0]   rd,
  input  logic            rd_en,
  input  logic [NREG-1:0] busy,
  output logic            ready
);

  logic hz_a, hz_b, hz_d;

  always_comb begin
    hz_a  = ra_en & busy[ra];
    hz_b  = rb_en & busy[rb];
    hz_d  = rd_en & busy[rd];
    ready = vld & ~(hz_a | hz_b | hz_d);
  end

endmodule

// File: rtl/di_pair_rule.sv
module di_pair_rule
  import dual_issue_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RW = $clog2(NREG)
) (
  input  logic [2:0]    cls0,
  input  logic [RW-1:0] rd0,
  input  logic          rd_en0,
  input  logic [2:0]    cls1,
  input  logic [RW-1:0] ra1,
  input  logic          ra_en1,
  input  logic [RW-1:0] rb1,
  input  logic          rb_en1,
  input  logic [RW-1:0] rd1,
  input  logic          rd_en1,
  output logic          pair_ok
);

  logic mix_ok, no_branch, raw_hit, waw_hit;

  always_comb begin
    mix_ok    = cls_is_fp(cls0) ^ cls_is_fp(cls1);
    no_branch = ~cls_is_br(cls0) & ~cls_is_br(cls1);
    raw_hit   = rd_en0 & ((ra_en1 & (ra1 == rd0)) | (rb_en1 & (rb1 == rd0)));
    waw_hit   = rd_en0 & rd_en1 & (rd1 == rd0);
    pair_ok   = mix_ok & no_branch & ~raw_hit & ~waw_hit;
  end

endmodule

// File: rtl/di_fp_busy.sv
module di_fp_busy #(
  parameter int NREG   = 32,
  parameter int FP_LAT = 3,
  localparam int RW = $clog2(NREG),
  localparam int CW = $clog2(FP_LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_idx,
  output logic [NREG-1:0] busy_o
);

  localparam logic [CW-1:0] LAT_LOAD = CW'(FP_LAT);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit, ce;

    always_comb begin
      hit = set_en & (set_idx == RW'(i));
      ce  = hit | (cnt_q != '0);
      if (hit) cnt_d = LAT_LOAD;
      else     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt_q <= '0;
      else if (ce) cnt_q <= cnt_d;
    end

    assign busy_o[i] = (cnt_q != '0);

    // R7
    lat_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> busy_o[i]);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o[i] && !hit) |=> !busy_o[i]);
  end

endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
  import dual_issue_pkg::*;
#(
  parameter int NREG   = 32,
  parameter int FP_LAT = 3,
  localparam int RW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s0_vld,
  input  logic [2:0]      s0_cls,
  input  logic [RW-1:0]   s0_ra,
  input  logic            s0_ra_en,
  input  logic [RW-1:0]   s0_rb,
  input  logic            s0_rb_en,
  input  logic [RW-1:0]   s0_rd,
  input  logic            s0_rd_en,
  input  logic            s1_vld,
  input  logic [2:0]      s1_cls,
  input  logic [RW-1:0]   s1_ra,
  input  logic            s1_ra_en,
  input  logic [RW-1:0]   s1_rb,
  input  logic            s1_rb_en,
  input  logic [RW-1:0]   s1_rd,
  input  logic            s1_rd_en,
  input  logic [NREG-1:0] ext_busy,
  output logic [1:0]      issue_cnt,
  output logic            int_vld,
  output logic            int_slot,
  output logic            fp_vld,
  output logic            fp_slot
);

  localparam int NSLOT = 2;

  logic            vld   [NSLOT];
  logic [RW-1:0]   ra    [NSLOT];
  logic            ra_en [NSLOT];
  logic [RW-1:0]   rb    [NSLOT];
  logic            rb_en [NSLOT];
  logic [RW-1:0]   rd    [NSLOT];
  logic            rd_en [NSLOT];
  logic            rdy   [NSLOT];
  logic [NREG-1:0] local_busy, all_busy;
  logic            pair_ok, iss0, iss1, fp0, fp1;
  logic            set_en;
  logic [RW-1:0]   set_idx;

  always_comb begin
    vld[0] = s0_vld;   ra[0] = s0_ra;   ra_en[0] = s0_ra_en;
    rb[0]  = s0_rb;    rb_en[0] = s0_rb_en; rd[0] = s0_rd; rd_en[0] = s0_rd_en;
    vld[1] = s1_vld;   ra[1] = s1_ra;   ra_en[1] = s1_ra_en;
    rb[1]  = s1_rb;    rb_en[1] = s1_rb_en; rd[1] = s1_rd; rd_en[1] = s1_rd_en;
    all_busy = ext_busy | local_busy;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    di_slot_hazard #(.NREG(NREG)) u_hz (
      .vld(vld[g]), .ra(ra[g]), .ra_en(ra_en[g]), .rb(rb[g]), .rb_en(rb_en[g]),
      .rd(rd[g]), .rd_en(rd_en[g]), .busy(all_busy), .ready(rdy[g])
    );
  end

  di_pair_rule #(.NREG(NREG)) u_pair (
    .cls0(s0_cls), .rd0(s0_rd), .rd_en0(s0_rd_en),
    .cls1(s1_cls), .ra1(s1_ra), .ra_en1(s1_ra_en), .rb1(s1_rb), .rb_en1(s1_rb_en),
    .rd1(s1_rd), .rd_en1(s1_rd_en), .pair_ok(pair_ok)
  );

  // next-issue decision and pipe steering
  always_comb begin
    fp0  = cls_is_fp(s0_cls);
    fp1  = cls_is_fp(s1_cls);
    iss0 = rdy[0];
    iss1 = iss0 & rdy[1] & pair_ok;
    issue_cnt = iss1 ? 2'd2 : (iss0 ? 2'd1 : 2'd0);
    int_vld  = (iss0 & ~fp0) | (iss1 & ~fp1);
    int_slot = ~(iss0 & ~fp0);
    fp_vld   = (iss0 & fp0) | (iss1 & fp1);
    fp_slot  = ~(iss0 & fp0);
    set_en   = fp_vld & (fp_slot ? s1_rd_en : s0_rd_en);
    set_idx  = fp_slot ? s1_rd : s0_rd;
  end

  di_fp_busy #(.NREG(NREG), .FP_LAT(FP_LAT)) u_busy (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_idx(set_idx), .busy_o(local_busy)
  );

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cnt != 2'd3);

  // R2
  pair_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt == 2'd2) |-> (s0_cls[2] != s1_cls[2]));

  // R3
  branch_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt == 2'd2) |-> (s0_cls != 3'd3 && s1_cls != 3'd3));

  // R5
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cnt != 2'd0) |-> s0_vld);

  // R8
  route_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({int_vld, fp_vld}) == int'(issue_cnt));

endmodule

// File: tb/sim_dual_issue_ctl.sv
`timescale 1ns/1ps
module sim_dual_issue_ctl;

  localparam int NREG = 32;
  localparam int RW   = 5;
  localparam int LAT  = 3;

  typedef struct packed {
    logic          v;
    logic [2:0]    c;
    logic [RW-1:0] a;
    logic          ae;
    logic [RW-1:0] b;
    logic          be;
    logic [RW-1:0] d;
    logic          de;
  } slot_t;

  typedef struct packed {
    slot_t      s0;
    slot_t      s1;
    int         bsy;
    logic [1:0] e_cnt;
    logic       e_iv, e_is, e_fv, e_fs;
  } tb_vec_t;

  function automatic slot_t op(int c, int a, int b, int d);
    slot_t s;
    s.v  = 1'b1;
    s.c  = 3'(c);
    s.ae = (a >= 0); s.a = (a >= 0) ? RW'(a) : '0;
    s.be = (b >= 0); s.b = (b >= 0) ? RW'(b) : '0;
    s.de = (d >= 0); s.d = (d >= 0) ? RW'(d) : '0;
    return s;
  endfunction

  localparam slot_t NOP = '0;

  // class codes: 0 ALU, 1 load, 2 store, 3 branch, 4 fadd, 5 fmul
  localparam tb_vec_t TBL [17] = '{
    '{op(0,2,3,1),   op(4,11,12,10), -1, 2'd2, 1, 0, 1, 1}, // R2 int+fp
    '{op(5,11,12,10), op(1,2,-1,1),  -1, 2'd2, 1, 1, 1, 0}, // R2 R8 fp+int
    '{op(0,2,3,1),   op(2,4,5,-1),   -1, 2'd1, 1, 0, 0, 0}, // R2 int+int
    '{op(4,11,12,10), op(5,13,14,15), -1, 2'd1, 0, 0, 1, 0}, // R2 fp+fp
    '{op(3,2,3,-1),  op(4,11,12,10), -1, 2'd1, 1, 0, 0, 0}, // R3 branch older
    '{op(0,2,3,1),   op(3,4,5,-1),   -1, 2'd1, 1, 0, 0, 0}, // R3 branch younger
    '{op(1,2,-1,5),  op(4,5,12,10),  -1, 2'd1, 1, 0, 0, 0}, // R4 RAW on a
    '{op(0,2,3,6),   op(5,11,6,10),  -1, 2'd1, 1, 0, 0, 0}, // R4 RAW on b
    '{op(0,2,3,5),   op(4,11,12,5),  -1, 2'd1, 1, 0, 0, 0}, // R4 WAW
    '{op(2,5,6,-1),  op(4,5,6,10),   -1, 2'd2, 1, 0, 1, 1}, // R4 no dest
    '{op(0,2,3,1),   op(4,11,12,10),  3, 2'd0, 0, 0, 0, 0}, // R6 slot0 src busy
    '{op(0,2,3,1),   op(4,11,12,10), 12, 2'd1, 1, 0, 0, 0}, // R6 slot1 src busy
    '{op(0,2,3,1),   op(4,11,12,10), 10, 2'd1, 1, 0, 0, 0}, // R6 slot1 dst busy
    '{op(0,-1,3,1),  op(4,11,12,10),  0, 2'd2, 1, 0, 1, 1}, // R6 disabled field
    '{NOP,           op(4,11,12,10), -1, 2'd0, 0, 0, 0, 0}, // R5 slot0 empty
    '{op(4,11,12,10), NOP,           -1, 2'd1, 0, 0, 1, 0}, // R5 slot1 empty
    '{op(4,11,12,10), op(0,2,3,1),   11, 2'd0, 0, 0, 0, 0}  // R5 older stalled
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  slot_t s0, s1;
  logic [NREG-1:0] ext_busy;
  logic [1:0] issue_cnt;
  logic int_vld, int_slot, fp_vld, fp_slot;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dual_issue_ctl #(.NREG(NREG), .FP_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n),
    .s0_vld(s0.v), .s0_cls(s0.c), .s0_ra(s0.a), .s0_ra_en(s0.ae),
    .s0_rb(s0.b), .s0_rb_en(s0.be), .s0_rd(s0.d), .s0_rd_en(s0.de),
    .s1_vld(s1.v), .s1_cls(s1.c), .s1_ra(s1.a), .s1_ra_en(s1.ae),
    .s1_rb(s1.b), .s1_rb_en(s1.be), .s1_rd(s1.d), .s1_rd_en(s1.de),
    .ext_busy(ext_busy), .issue_cnt(issue_cnt),
    .int_vld(int_vld), .int_slot(int_slot), .fp_vld(fp_vld), .fp_slot(fp_slot)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(slot_t a, slot_t b, int bsy);
    s0 = a;
    s1 = b;
    ext_busy = '0;
    if (bsy >= 0) ext_busy[bsy] = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog run did not finish");
    summary();
    $finish;
  end

  initial begin
    drive(NOP, NOP, -1);
    do_reset();
    #1;
    // R1 reset state with an empty window
    chk("R1", "reset cnt", int'(issue_cnt), 0);
    chk("R8", "reset int_vld", int'(int_vld), 0);
    chk("R8", "reset fp_vld", int'(fp_vld), 0);

    for (int i = 0; i < 17; i++) begin
      do_reset();
      drive(TBL[i].s0, TBL[i].s1, TBL[i].bsy);
      #1;
      chk("R1", $sformatf("row %0d cnt", i), int'(issue_cnt), int'(TBL[i].e_cnt));
      chk("R8", $sformatf("row %0d int_vld", i), int'(int_vld), int'(TBL[i].e_iv));
      chk("R8", $sformatf("row %0d fp_vld", i), int'(fp_vld), int'(TBL[i].e_fv));
      if (TBL[i].e_iv)
        chk("R8", $sformatf("row %0d int_slot", i), int'(int_slot), int'(TBL[i].e_is));
      if (TBL[i].e_fv)
        chk("R8", $sformatf("row %0d fp_slot", i), int'(fp_slot), int'(TBL[i].e_fs));
    end

    // R7 FP from slot 0: dependent stalls LAT cycles, issues after
    do_reset();
    drive(op(4,11,12,20), NOP, -1);
    #1;
    chk("R7", "fp issue", int'(issue_cnt), 1);
    for (int k = 1; k <= LAT + 1; k++) begin
      @(negedge clk);
      drive(op(0,20,3,1), NOP, -1);
      #1;
      chk("R7", $sformatf("dependent cycle %0d", k), int'(issue_cnt), (k <= LAT) ? 0 : 1);
    end

    // R7 FP paired in slot 1 also marks its destination
    do_reset();
    drive(op(0,2,3,1), op(5,11,12,21), -1);
    #1;
    chk("R7", "pair issue", int'(issue_cnt), 2);
    @(negedge clk);
    drive(op(4,21,12,22), NOP, -1);
    #1;
    chk("R7", "slot1 fp dest busy", int'(issue_cnt), 0);

    // R7 FP with destination disabled marks nothing
    do_reset();
    drive(op(4,11,12,-1), NOP, -1);
    @(negedge clk);
    drive(op(0,0,3,1), NOP, -1);
    #1;
    chk("R7", "no dest no busy", int'(issue_cnt), 1);

    // R9 reset clears internal busy state
    do_reset();
    drive(op(4,11,12,23), NOP, -1);
    @(negedge clk);
    drive(op(0,23,3,1), NOP, -1);
    #1;
    chk("R9", "busy before reset", int'(issue_cnt), 0);
    rst_n = 1'b0;
    #1;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9", "dependent after reset", int'(issue_cnt), 1);

    summary();
    $finish;
  end

endmodule